// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit timing of a CAN node. A programmable divider produces time quanta. Each nominal bit is split into a one-quantum synchronization segment, a first phase segment and a second phase segment. At the end of the first phase segment the receive line is sampled and a valid pulse is given with the sampled value. At the end of the second phase segment a transmit-point strobe is raised, so a transmitter can change its output there.

While the bus is idle, the controller raises a hard-sync enable. The next recessive-to-dominant edge on the receive line then restarts the bit. At all other times a falling edge resynchronizes the bit phase. A late edge stretches the first phase segment. An early edge cuts the second phase segment short. The correction never exceeds a programmable jump width. An optional mode replaces the single sample with a 2-of-3 majority of three samples taken one quantum apart. Frame decoding, stuffing and arbitration are left to the logic that consumes the sampled bits.

All configuration fields hold the real value minus one. A quantum lasts (cfg_qdiv+1) clock cycles. A bit lasts 1 + (cfg_ph1+1) + (cfg_ph2+1) quanta, for example 14 quanta with phase segments of 6 and 7.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is applied and in the cycle after it is released, samp_vld, tx_pt and samp_bit are all 0.
- R2: With the receive line held at 1 and hard sync off, samp_vld pulses every (cfg_qdiv+1)*(cfg_ph1+cfg_ph2+3) clock cycles.
- R3: tx_pt pulses exactly (cfg_ph2+1) quanta after each samp_vld pulse. The two pulses never coincide, and every tx_pt has a samp_vld pulse since the previous tx_pt.
- R4: With cfg_triple=0, samp_bit carries the value rx_in had on the clock edge that ends the first phase segment. samp_bit is held between pulses.
- R5: With sync_en=1, a 1-to-0 change of rx_in, seen on a quantum boundary, makes that quantum the synchronization segment. The next sample follows cfg_ph1+1 quanta later.
- R6: With sync_en=0, a falling edge in quantum k (1-based) of the first phase segment lengthens that segment by min(k, cfg_jump+1) quanta.
- R7: With sync_en=0, a falling edge in a quantum of the second phase segment with e quanta left (that quantum included) is handled as follows. If e <= cfg_jump+1, the edge quantum becomes the synchronization segment of a new bit. Otherwise the segment is shortened by cfg_jump+1 quanta.
- R8: A bit in which a hard sync or a resynchronization took place receives no further resynchronization.
- R9: A 0-to-1 change of rx_in does not move the bit phase.
- R10: With cfg_triple=1, samp_bit is the majority of rx_in on the last three quantum boundaries up to and including the sample point.
- R11: samp_vld and tx_pt rise only on quantum boundaries. After reset the first sample arrives (cfg_ph1+2)*(cfg_qdiv+1) cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Receive line, already synchronized to clk (1 = recessive) |
| sync_en | input | 1 | Bus idle: the next falling edge hard-synchronizes |
| cfg_qdiv | input | BRP_W | Quantum length in clocks, minus one |
| cfg_ph1 | input | SEG1_W | First phase segment in quanta, minus one |
| cfg_ph2 | input | SEG2_W | Second phase segment in quanta, minus one |
| cfg_jump | input | SJW_W | Resynchronization jump width in quanta, minus one |
| cfg_triple | input | 1 | 1 = majority of three samples |
| samp_bit | output | 1 | Sampled bit value |
| samp_vld | output | 1 | One-cycle pulse: samp_bit is new |
| tx_pt | output | 1 | One-cycle transmit-point strobe |

## Verification
The assertions rely on two properties of the inputs. First, the configuration fields change only while reset is applied: the checker's quantum counter mirrors the divider from reset, and a mid-run change would break that alignment. Second, rx_in is synchronous to clk, so the value the checker reads one cycle later is the value that was sampled. The bench writes every configuration together with a reset pulse and drives rx_in only on falling clock edges. Edge placements are computed relative to a hard sync that the bench starts itself, with a one-clock quantum.

// File: rtl/cbt_pkg.sv
// Package: shared types of the CAN bit timing unit.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package cbt_pkg;

    // Segment of the nominal bit the current quantum belongs to.
    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_SEG1 = 2'd1,
        PH_SEG2 = 2'd2
    } phase_t;

    // Two-of-three majority used by the sampler.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cbt_prescaler.sv
// Quantum divider: gives a one-cycle tick every (qdiv+1) clocks.
// Assumes qdiv is stable outside reset; the count restarts at reset.
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] qdiv,
    output logic             tick
);

    logic [BRP_W-1:0] cnt;

    assign tick = (cnt == qdiv);

    // Count clock cycles inside one quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/cbt_edge.sv
// Edge detector: samples rx on every quantum tick and flags a
// recessive-to-dominant change between two consecutive ticks.
// Assumes rx is already synchronous to clk. The history resets to recessive.
module cbt_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    output logic       fall,
    output logic [1:0] hist
);

    assign fall = tick & hist[0] & ~rx;

    // Keep the rx values of the last two quantum boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)    hist <= 2'b11;
        else if (tick) hist <= {hist[0], rx};
    end

endmodule

// File: rtl/cbt_vote.sv
// Sample selector: passes the current rx value, or the 2-of-3 majority
// of the last three quantum-boundary values when triple mode is on.
// Purely combinational.
module cbt_vote (
    input  logic [1:0] hist,
    input  logic       rx,
    input  logic       triple,
    output logic       bit_o
);
    import cbt_pkg::*;

    // Choose single or majority sample.
    always_comb begin
        bit_o = triple ? maj3(hist[1], hist[0], rx) : rx;
    end

endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing unit: splits each bit into a sync quantum and two phase
// segments, samples at the end of the first and strobes at the end of
// the second. It hard-synchronizes on idle-bus edges and otherwise
// resynchronizes, with the correction limited by the jump width.
// Assumes the cfg_* fields are stable outside reset and rx_in is synchronous.
module can_bit_timer #(
    parameter int BRP_W  = 6,
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              sync_en,
    input  logic [BRP_W-1:0]  cfg_qdiv,
    input  logic [SEG1_W-1:0] cfg_ph1,
    input  logic [SEG2_W-1:0] cfg_ph2,
    input  logic [SJW_W-1:0]  cfg_jump,
    input  logic              cfg_triple,
    output logic              samp_bit,
    output logic              samp_vld,
    output logic              tx_pt
);
    import cbt_pkg::*;

    localparam int LEN_W = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 2;

    logic             tick, fall, voted;
    logic [1:0]       hist;
    phase_t           phase, phase_n;
    logic [LEN_W-1:0] cnt, cnt_n, len, len_n, len_t, err;
    logic [LEN_W-1:0] l1, l2, sjw;
    logic             done, done_n, vld_n, tx_n, bit_n, jumped;

    assign l1  = LEN_W'(cfg_ph1)  + LEN_W'(1);
    assign l2  = LEN_W'(cfg_ph2)  + LEN_W'(1);
    assign sjw = LEN_W'(cfg_jump) + LEN_W'(1);

    cbt_prescaler #(.BRP_W(BRP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .qdiv(cfg_qdiv), .tick(tick)
    );

    cbt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_in),
        .fall(fall), .hist(hist)
    );

    cbt_vote u_vote (
        .hist(hist), .rx(rx_in), .triple(cfg_triple), .bit_o(voted)
    );

    // Decide the next segment, position and length at each quantum tick.
    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        len_n   = len;
        len_t   = len;
        err     = '0;
        done_n  = done;
        vld_n   = 1'b0;
        tx_n    = 1'b0;
        bit_n   = samp_bit;
        jumped  = 1'b0;
        if (tick) begin
            if (fall && sync_en) begin
                phase_n = PH_SEG1;
                cnt_n   = '0;
                len_n   = l1;
                done_n  = 1'b1;
            end else begin
                unique case (phase)
                    PH_SYNC: begin
                        phase_n = PH_SEG1;
                        cnt_n   = '0;
                        len_n   = l1;
                    end
                    PH_SEG1: begin
                        if (fall && !done) begin
                            err    = cnt + LEN_W'(1);
                            len_t  = len + ((err < sjw) ? err : sjw);
                            done_n = 1'b1;
                        end
                        if (cnt == len_t - LEN_W'(1)) begin
                            vld_n   = 1'b1;
                            bit_n   = voted;
                            phase_n = PH_SEG2;
                            cnt_n   = '0;
                            len_n   = l2;
                        end else begin
                            cnt_n = cnt + LEN_W'(1);
                            len_n = len_t;
                        end
                    end
                    PH_SEG2: begin
                        if (fall && !done) begin
                            err    = len - cnt;
                            done_n = 1'b1;
                            if (err <= sjw) begin
                                jumped  = 1'b1;
                                tx_n    = 1'b1;
                                phase_n = PH_SEG1;
                                cnt_n   = '0;
                                len_n   = l1;
                            end else begin
                                len_t = len - sjw;
                            end
                        end
                        if (!jumped) begin
                            if (cnt == len_t - LEN_W'(1)) begin
                                tx_n    = 1'b1;
                                phase_n = PH_SYNC;
                                done_n  = 1'b0;
                                cnt_n   = '0;
                            end else begin
                                cnt_n = cnt + LEN_W'(1);
                                len_n = len_t;
                            end
                        end
                    end
                    default: phase_n = PH_SYNC;
                endcase
            end
        end
    end

    // Register the bit state and the output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_SYNC;
            cnt      <= '0;
            len      <= LEN_W'(1);
            done     <= 1'b0;
            samp_vld <= 1'b0;
            samp_bit <= 1'b0;
            tx_pt    <= 1'b0;
        end else begin
            phase    <= phase_n;
            cnt      <= cnt_n;
            len      <= len_n;
            done     <= done_n;
            samp_vld <= vld_n;
            samp_bit <= bit_n;
            tx_pt    <= tx_n;
        end
    end

endmodule

// File: rtl/cbt_checker.sv
// Property checker for can_bit_timer, attached by bind.
// Assumes cfg_qdiv changes only while reset is applied and rx_in is synchronous.
module cbt_checker #(
    parameter int BRP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_in,
    input logic [BRP_W-1:0] cfg_qdiv,
    input logic             cfg_triple,
    input logic             samp_bit,
    input logic             samp_vld,
    input logic             tx_pt
);

    logic [BRP_W-1:0] qctr;
    logic             pend;

    // Independent quantum position counter.
    always_ff @(posedge clk) begin
        if (!rst_n)               qctr <= '0;
        else if (qctr == cfg_qdiv) qctr <= '0;
        else                       qctr <= qctr + 1'b1;
    end

    // Remember whether a sample has come since the last transmit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (samp_vld) pend <= 1'b1;
        else if (tx_pt)    pend <= 1'b0;
    end

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_vld && tx_pt));

    p_tx_after_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pt |-> pend);

    p_sample_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> !samp_vld);

    p_single_sample_r4: assert property (@(posedge clk) disable iff (!rst_n || cfg_triple)
        samp_vld |-> (samp_bit == $past(rx_in)));

    p_quantum_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld || tx_pt) |-> (qctr == '0));

endmodule

bind can_bit_timer cbt_checker #(.BRP_W(BRP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_qdiv(cfg_qdiv),
    .cfg_triple(cfg_triple), .samp_bit(samp_bit), .samp_vld(samp_vld),
    .tx_pt(tx_pt)
);

// File: tb/sim_can_bit_timer.sv
// Bench for can_bit_timer: sweeps small configurations and edge placements.
module sim_can_bit_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       sync_en = 1'b0;
    logic [5:0] cfg_qdiv = '0;
    logic [3:0] cfg_ph1 = '0;
    logic [2:0] cfg_ph2 = '0;
    logic [1:0] cfg_jump = '0;
    logic       cfg_triple = 1'b0;
    logic       samp_bit, samp_vld, tx_pt;

    int total = 0;
    int bad   = 0;
    int pidx  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sync_en(sync_en),
        .cfg_qdiv(cfg_qdiv), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2),
        .cfg_jump(cfg_jump), .cfg_triple(cfg_triple),
        .samp_bit(samp_bit), .samp_vld(samp_vld), .tx_pt(tx_pt)
    );

    task automatic check_eq(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic restart(input int q, input int p1, input int p2, input int j, input bit tr);
        @(negedge clk);
        rst_n = 1'b0; rx_in = 1'b1; sync_en = 1'b0;
        cfg_qdiv = 6'(q); cfg_ph1 = 4'(p1); cfg_ph2 = 3'(p2);
        cfg_jump = 2'(j); cfg_triple = tr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pidx = 0;
    endtask

    // Advance to the falling edge that follows posedge number m.
    task automatic go_to(input int m);
        while (pidx < m) begin
            @(negedge clk);
            pidx++;
        end
    endtask

    // Count clock edges until samp_vld is seen.
    task automatic to_sample(output int n);
        n = 0;
        do begin
            @(negedge clk);
            pidx++;
            n++;
        end while (!samp_vld && n < 400);
    endtask

    task automatic to_tx(output int n);
        n = 0;
        do begin
            @(negedge clk);
            pidx++;
            n++;
        end while (!tx_pt && n < 400);
    endtask

    // Hard sync with a one-clock quantum; afterwards pidx 0 is "after P0".
    task automatic hard_sync();
        sync_en = 1'b1;
        repeat (3) @(negedge clk);
        rx_in = 1'b0;
        pidx = 0;
        go_to(1);
        sync_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, l1, l2, s, nb, e, exp;
        // R1: reset state
        restart(0, 5, 6, 0, 0);
        check_eq("R1 samp_vld", int'(samp_vld), 0);
        check_eq("R1 tx_pt", int'(tx_pt), 0);
        check_eq("R1 samp_bit", int'(samp_bit), 0);

        // R2, R3, R4, R11: free-running sweep over divider and segments
        for (int q = 0; q < 3; q++)
            for (int p1 = 0; p1 < 16; p1++)
                for (int p2 = 0; p2 < 8; p2++) begin
                    restart(q, p1, p2, 0, 0);
                    to_sample(n);
                    check_eq("R11 first sample", n, (p1 + 2) * (q + 1));
                    check_eq("R4 idle bit", int'(samp_bit), 1);
                    to_tx(n);
                    check_eq("R3 tx offset", n, (p2 + 1) * (q + 1));
                    to_sample(n);
                    check_eq("R2 bit period", n, (q + 1) * (p1 + p2 + 3) - (p2 + 1) * (q + 1));
                end

        // R5: hard sync restarts the bit
        for (int p1 = 0; p1 < 16; p1++) begin
            restart(0, p1, 3, 0, 0);
            sync_en = 1'b1;
            repeat (5) @(negedge clk);
            rx_in = 1'b0;
            to_sample(n);
            check_eq("R5 hard sync delay", n, p1 + 2);
            check_eq("R5 sampled dominant", int'(samp_bit), 0);
        end

        // R6: late edge lengthens the first phase segment
        for (int p1 = 0; p1 < 6; p1++)
            for (int j = 0; j < 4; j++)
                for (int c = 0; c <= p1; c++) begin
                    l1 = p1 + 1; l2 = 4; s = j + 1; nb = 1 + l1 + l2;
                    restart(0, p1, 3, j, 0);
                    hard_sync();
                    go_to(2); rx_in = 1'b1;
                    go_to(nb + 1 + c); rx_in = 1'b0;
                    to_sample(n);
                    exp = l1 - c + (((c + 1) < s) ? (c + 1) : s);
                    check_eq("R6 late edge", n, exp);
                end

        // R7: early edge shortens the second phase segment
        for (int p2 = 0; p2 < 8; p2++)
            for (int j = 0; j < 4; j++)
                for (int k = 0; k <= p2; k++) begin
                    l1 = 4; l2 = p2 + 1; s = j + 1; nb = 1 + l1 + l2;
                    restart(0, 3, p2, j, 0);
                    hard_sync();
                    go_to(2); rx_in = 1'b1;
                    go_to(nb + 1 + l1 + k); rx_in = 1'b0;
                    to_sample(n);
                    e = l2 - k;
                    exp = (e <= s) ? (l1 + 1) : (1 + l1 + l2 - s - k);
                    check_eq("R7 early edge", n, exp);
                end

        // R8: no resync in a bit that was hard-synchronized
        for (int j = 0; j < 4; j++) begin
            restart(0, 5, 3, j, 0);
            hard_sync();
            go_to(2); rx_in = 1'b1;
            go_to(3); rx_in = 1'b0;
            to_sample(n);
            check_eq("R8 no second correction", n, 4);
        end

        // R9: rising edge leaves the phase alone
        for (int c = 0; c < 4; c++) begin
            l1 = 5; nb = 1 + 5 + 3;
            restart(0, 4, 2, 3, 0);
            hard_sync();
            go_to(nb + 1 + c); rx_in = 1'b1;
            to_sample(n);
            check_eq("R9 rise ignored", n, l1 - c);
            check_eq("R9 sampled recessive", int'(samp_bit), 1);
        end

        // R10 and R4: majority versus single sample on monotone patterns
        for (int tr = 0; tr < 2; tr++)
            for (int p1i = 0; p1i < 3; p1i++)
                for (int pi = 0; pi < 4; pi++) begin
                    int p1, pat, ones;
                    p1  = (p1i == 0) ? 1 : ((p1i == 1) ? 3 : 5);
                    pat = (pi == 0) ? 0 : ((pi == 1) ? 4 : ((pi == 2) ? 6 : 7));
                    l1 = p1 + 1; nb = 1 + l1 + 3;
                    restart(0, p1, 2, 3, tr[0]);
                    hard_sync();
                    go_to(nb + l1 - 2); rx_in = pat[0];
                    go_to(nb + l1 - 1); rx_in = pat[1];
                    go_to(nb + l1);     rx_in = pat[2];
                    go_to(nb + 1 + l1);
                    check_eq("R10 sample pulse", int'(samp_vld), 1);
                    ones = pat[0] + pat[1] + pat[2];
                    if (tr == 1) check_eq("R10 majority", int'(samp_bit), (ones >= 2) ? 1 : 0);
                    else         check_eq("R4 single sample", int'(samp_bit), pat[2]);
                end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule